// File: doc/BRIEF.md
# Two-Channel DMA Burst Arbiter

This block sits between the transmit and receive FIFOs of an Ethernet MAC and the DMA engine that moves data over a system bus. It decides when a burst may start and which channel gets the bus. A burst is measured in 64-bit beats, and a 3-bit length code sets how many beats make one burst. The transmit channel asks for the bus once its FIFO has room for a whole burst. The receive channel asks once its FIFO holds a whole burst of data.

A mode bit selects the arbitration policy. In fixed mode, receive always wins over transmit. In shared mode, the two channels take turns when both are asking. Once a burst is granted, the grant is held until the programmed number of beat acknowledges has been counted. The block then spends one cycle idle, and the next decision is made in that cycle.

The controller has three states:
- `ST_IDLE`: no grant. From here it moves to `ST_RX_BURST` or `ST_TX_BURST` when a request wins, or stays in `ST_IDLE` when nothing is requested.
- `ST_RX_BURST` and `ST_TX_BURST`: each holds its grant. On the final beat acknowledge it moves back to `ST_IDLE`. On any other cycle it stays where it is.

Top module: `dma_burst_arbiter`

## Requirements
- R1: The burst length in beats is 2 when `burst_len[1:0]` is 00, 4 when it is 01, 8 when it is 10 and 16 when it is 11. Bit 2 of `burst_len` has no effect on the length.
- R2: A transmit request exists only when `tx_free` is greater than or equal to the burst length. A transmit grant starts only from such a request.
- R3: A receive request exists only when `rx_fill` is greater than or equal to the burst length. A receive grant starts only from such a request.
- R4: When `rr_mode` is 0 and both channels request in the idle state, the receive channel is granted.
- R5: When `rr_mode` is 1 and both channels request in the idle state, the channel not granted most recently wins. After reset, transmit counts as the channel granted most recently, so receive wins the first tie.
- R6: A granted burst holds its grant and keeps `burst_active` at 1 until exactly the burst length's number of `beat_ack` pulses has been counted. `burst_done` is 1 during the cycle of the final acknowledged beat and 0 at every other time.
- R7: The burst length is captured when the grant is issued. Changing `burst_len` during a burst does not change the number of beats in that burst.
- R8: After reset, `grant_rx`, `grant_tx`, `burst_active` and `burst_done` are all 0.
- R9: At most one grant is high at any time, and `burst_active` is high exactly when one grant is high.
- R10: In the cycle after `burst_done`, both grants and `burst_active` are 0. If a request is present in that cycle, the next grant appears one cycle later.
- R11: A `beat_ack` received while idle is ignored. It does not shorten the beat count of the next burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| burst_len | input | 3 | Burst length code (see R1) |
| rr_mode | input | 1 | 1 selects round-robin sharing, 0 selects fixed receive priority |
| tx_free | input | 8 | Free 64-bit entries in the transmit FIFO (0 to 128) |
| rx_fill | input | 8 | Stored 64-bit entries in the receive FIFO (0 to 128) |
| beat_ack | input | 1 | The bus accepted one 64-bit beat of the granted burst |
| grant_rx | output | 1 | The receive channel owns the current burst |
| grant_tx | output | 1 | The transmit channel owns the current burst |
| burst_active | output | 1 | A burst is in progress |
| burst_done | output | 1 | The current acknowledge completes the burst |

## Verification
The hardest case to reach is the round-robin tie. It needs both channels requesting in the idle cycle that follows a burst, while the "granted most recently" history points one particular way.

The bench reaches it by holding both FIFO levels at their maximum for several bursts back to back in shared mode. This shows that receive and transmit alternate, with an idle cycle between bursts. The same held-high pattern in fixed mode shows receive winning every time.

Two more cases are forced directly:
- a length code changed in the middle of a burst, which tests the length capture of R7;
- a stray acknowledge while idle, which tests R11.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RX_BURST = 2'd1,
        ST_TX_BURST = 2'd2
    } arb_state_t;
endpackage

// File: rtl/dma_burst_decode.sv
module dma_burst_decode #(
    parameter int CODE_W = 3,
    parameter int BEAT_W = 5
) (
    input  logic [CODE_W-1:0] code,
    output logic [BEAT_W-1:0] beats
);
    logic unused_high;
    assign unused_high = ^code[CODE_W-1:2];

    always_comb begin
        beats = BEAT_W'(2) << code[1:0];
    end

    // R1
    always_comb begin
        decode_range_chk: assert (beats >= BEAT_W'(2) && beats <= BEAT_W'(16));
    end
endmodule

// File: rtl/dma_level_req.sv
module dma_level_req #(
    parameter int LVL_W  = 8,
    parameter int BEAT_W = 5
) (
    input  logic [LVL_W-1:0]  level,
    input  logic [BEAT_W-1:0] beats,
    output logic              req
);
    always_comb begin
        req = (level >= LVL_W'(beats));
    end
endmodule

// File: rtl/dma_beat_counter.sv
module dma_beat_counter #(
    parameter int BEAT_W     = 5,
    parameter int RESET_LEN  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BEAT_W-1:0] beats_in,
    input  logic              active,
    input  logic              ack,
    output logic              last_beat
);
    logic [BEAT_W-1:0] len_q;
    logic [BEAT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= BEAT_W'(RESET_LEN);
            cnt_q <= '0;
        end else if (start) begin
            len_q <= beats_in;
            cnt_q <= '0;
        end else if (active && ack) begin
            cnt_q <= cnt_q + BEAT_W'(1);
        end
    end

    always_comb begin
        last_beat = active && ack && (cnt_q == len_q - BEAT_W'(1));
    end

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt_q < len_q));

    // R7
    len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !start) |=> (start || $stable(len_q)));
endmodule

// File: rtl/dma_burst_arbiter.sv
module dma_burst_arbiter
    import dma_arb_pkg::*;
#(
    parameter int CODE_W   = 3,
    parameter int FIFO_DEP = 128,
    parameter int MAX_BEAT = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [CODE_W-1:0]            burst_len,
    input  logic                         rr_mode,
    input  logic [$clog2(FIFO_DEP+1)-1:0] tx_free,
    input  logic [$clog2(FIFO_DEP+1)-1:0] rx_fill,
    input  logic                         beat_ack,
    output logic                         grant_rx,
    output logic                         grant_tx,
    output logic                         burst_active,
    output logic                         burst_done
);
    localparam int LVL_W  = $clog2(FIFO_DEP + 1);
    localparam int BEAT_W = $clog2(MAX_BEAT + 1);

    arb_state_t state_q, state_d;
    logic [BEAT_W-1:0] beats;
    logic tx_req, rx_req;
    logic last_tx_q;
    logic start;
    logic last_beat;

    dma_burst_decode #(.CODE_W(CODE_W), .BEAT_W(BEAT_W)) u_decode (
        .code  (burst_len),
        .beats (beats)
    );

    dma_level_req #(.LVL_W(LVL_W), .BEAT_W(BEAT_W)) u_tx_req (
        .level (tx_free),
        .beats (beats),
        .req   (tx_req)
    );

    dma_level_req #(.LVL_W(LVL_W), .BEAT_W(BEAT_W)) u_rx_req (
        .level (rx_fill),
        .beats (beats),
        .req   (rx_req)
    );

    dma_beat_counter #(.BEAT_W(BEAT_W), .RESET_LEN(MAX_BEAT)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .beats_in  (beats),
        .active    (burst_active),
        .ack       (beat_ack),
        .last_beat (last_beat)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            last_tx_q <= 1'b1;
        end else begin
            state_q <= state_d;
            if (state_d == ST_TX_BURST && state_q == ST_IDLE) begin
                last_tx_q <= 1'b1;
            end else if (state_d == ST_RX_BURST && state_q == ST_IDLE) begin
                last_tx_q <= 1'b0;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rx_req && tx_req) begin
                    if (rr_mode && !last_tx_q) begin
                        state_d = ST_TX_BURST;
                    end else begin
                        state_d = ST_RX_BURST;
                    end
                end else if (rx_req) begin
                    state_d = ST_RX_BURST;
                end else if (tx_req) begin
                    state_d = ST_TX_BURST;
                end
            end
            ST_RX_BURST, ST_TX_BURST: begin
                if (last_beat) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        grant_rx     = (state_q == ST_RX_BURST);
        grant_tx     = (state_q == ST_TX_BURST);
        burst_active = grant_rx || grant_tx;
        burst_done   = last_beat;
        start        = (state_q == ST_IDLE) && (state_d != ST_IDLE);
    end

    // R9
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({grant_rx, grant_tx}));

    // R4
    rx_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_active && !rr_mode && rx_req) |=> grant_rx);

    // R5
    rr_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_active && rr_mode && rx_req && tx_req && last_tx_q) |=> grant_rx);

    // R2
    tx_need_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_tx) |-> $past(tx_req));

    // R3
    rx_need_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_rx) |-> $past(rx_req));

    // R6
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_active && !burst_done) |=> (burst_active && $stable(grant_tx)));

    // R10
    idle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |=> !burst_active);

    // R6
    done_only_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |-> burst_active);
endmodule

// File: tb/tb_dma_burst_arbiter.sv
`timescale 1ns/1ps
module tb_dma_burst_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] burst_len = 3'b011;
    logic       rr_mode = 1'b0;
    logic [7:0] tx_free = '0;
    logic [7:0] rx_fill = '0;
    logic       beat_ack = 1'b0;
    logic       grant_rx, grant_tx, burst_active, burst_done;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dma_burst_arbiter dut (
        .clk(clk), .rst_n(rst_n), .burst_len(burst_len), .rr_mode(rr_mode),
        .tx_free(tx_free), .rx_fill(rx_fill), .beat_ack(beat_ack),
        .grant_rx(grant_rx), .grant_tx(grant_tx),
        .burst_active(burst_active), .burst_done(burst_done)
    );

    // {burst_len[2:0], tx_free[7:0], rx_fill[7:0], expect[1:0]} expect: 0 none, 1 rx, 2 tx
    localparam int NV = 9;
    localparam logic [20:0] VEC [NV] = '{
        {3'b000, 8'd2,   8'd0,   2'd2},
        {3'b000, 8'd1,   8'd1,   2'd0},
        {3'b001, 8'd0,   8'd4,   2'd1},
        {3'b010, 8'd8,   8'd8,   2'd1},
        {3'b011, 8'd15,  8'd16,  2'd1},
        {3'b111, 8'd16,  8'd15,  2'd2},
        {3'b110, 8'd128, 8'd7,   2'd2},
        {3'b101, 8'd3,   8'd3,   2'd0},
        {3'b100, 8'd128, 8'd128, 2'd1}
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int grant_code();
        return grant_tx ? 2 : (grant_rx ? 1 : 0);
    endfunction

    // From a negedge with the grant already visible: acks n beats, with a gap every other beat.
    task automatic run_burst(input string tag, input int n, input int ch);
        for (int k = 1; k <= n; k++) begin
            if (k % 2 == 0) begin
                beat_ack = 1'b0;
                @(posedge clk); @(negedge clk);
                check({tag, " R6 grant held in gap"}, grant_code(), ch);
            end
            beat_ack = 1'b1;
            #1;
            check({tag, " R6 burst_done"}, int'(burst_done), (k == n) ? 1 : 0);
            check({tag, " R9 active matches grant"}, int'(burst_active), 1);
            @(posedge clk); @(negedge clk);
        end
        beat_ack = 1'b0;
        check({tag, " R10 idle after done"}, int'(burst_active), 0);
    endtask

    task automatic drive_and_wait(input logic [2:0] bl, input logic [7:0] tf, input logic [7:0] rf);
        burst_len = bl; tx_free = tf; rx_fill = rf;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tx_free = '0; rx_fill = '0; beat_ack = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R8
        check("R8 grant_rx after reset", int'(grant_rx), 0);
        check("R8 grant_tx after reset", int'(grant_tx), 0);
        check("R8 burst_active after reset", int'(burst_active), 0);
        check("R8 burst_done after reset", int'(burst_done), 0);

        // R1 R2 R3 R4: table walk in fixed mode
        rr_mode = 1'b0;
        for (int i = 0; i < NV; i++) begin
            logic [2:0] bl;
            int exp_ch, n;
            bl = VEC[i][20:18];
            exp_ch = int'(VEC[i][1:0]);
            n = 2 << bl[1:0];
            drive_and_wait(bl, VEC[i][17:10], VEC[i][9:2]);
            check($sformatf("R2 R3 R4 vector %0d grant", i), grant_code(), exp_ch);
            if (exp_ch != 0) begin
                run_burst($sformatf("R1 vector %0d", i), n, exp_ch);
            end
            tx_free = '0; rx_fill = '0;
            @(posedge clk); @(negedge clk);
            check($sformatf("vector %0d R9 idle", i), int'(burst_active), 0);
        end

        // R7: change length code mid-burst
        drive_and_wait(3'b000, 8'd0, 8'd2);
        check("R7 grant rx", grant_code(), 1);
        burst_len = 3'b011;
        run_burst("R7 length captured", 2, 1);
        rx_fill = '0;
        @(posedge clk); @(negedge clk);

        // R11: stray ack while idle
        burst_len = 3'b001;
        beat_ack = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R11 no grant from stray ack", int'(burst_active), 0);
        beat_ack = 1'b0;
        drive_and_wait(3'b001, 8'd4, 8'd0);
        check("R11 grant tx", grant_code(), 2);
        run_burst("R11 full count", 4, 2);
        tx_free = '0;
        @(posedge clk); @(negedge clk);

        // R5: round-robin with both held high
        do_reset();
        rr_mode = 1'b1;
        drive_and_wait(3'b000, 8'd128, 8'd128);
        check("R5 first tie rx", grant_code(), 1);
        run_burst("R5 b1", 2, 1);
        @(posedge clk); @(negedge clk);
        check("R5 R10 second tie tx", grant_code(), 2);
        run_burst("R5 b2", 2, 2);
        @(posedge clk); @(negedge clk);
        check("R5 third tie rx", grant_code(), 1);
        run_burst("R5 b3", 2, 1);

        // R4: fixed mode with both held high stays on rx
        rr_mode = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R4 fixed repeats rx", grant_code(), 1);
        run_burst("R4 b", 2, 1);
        tx_free = '0; rx_fill = '0;
        @(posedge clk); @(negedge clk);
        check("R9 final idle", int'(grant_rx) + int'(grant_tx), 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule